// File: doc/BRIEF.md
# Interrupt Source Router

This block connects a 128-wide vector of event lines to twelve maskable CPU interrupt inputs, numbered 4 to 15. Event numbers 0 to 3 carry the combined events from an upstream event combiner. Numbers 4 to 127 are raw system events. Each interrupt output has its own source-select field, so any event can drive any output, and several outputs may share one event.

The select fields sit four to a configuration word, in three words. Every output is a registered copy of its chosen event. Each output also sets a sticky pending bit, and an acknowledge clears that bit. A fixed-order resolver reports the pending output that should be taken next. Output 4 has the highest priority and output 15 the lowest. The resolver only orders requests that are waiting, and it never withdraws a request that is already being handled.

Top module: `irq_src_router`

## Requirements
- R1: After a synchronous active-high reset, the select field of output n (n = 4..15) holds event number n, all interrupt outputs are 0, all pending bits are 0 and top_valid_o is 0.
- R2: Configuration word 1 holds the selects for outputs 4..7, word 2 for outputs 8..11 and word 3 for outputs 12..15. Within a word, the lowest-numbered output uses bits 6:0 and the next ones use bits 14:8, 22:16 and 30:24. All other bits read as 0. Address 0 reads as 0, and a write to address 0 changes no field.
- R3: irq_o bit k (output k+4) equals the value of the event its field selects, sampled at the previous rising clock edge (one cycle of latency).
- R4: Any event number 0..127 can be chosen, including the combined events 0..3. Several outputs that select the same event all assert together.
- R5: A pending bit is set when its selected event is high and stays set after the event falls, until it is acknowledged.
- R6: ack_i bit k clears pending bit k at the next edge. If the selected event is high in that same cycle, the bit stays set.
- R7: top_valid_o is 1 exactly when any pending bit is set. top_num_o then gives the lowest pending output number (4..15).
- R8: Acknowledging one output leaves the pending bits of the other outputs unchanged.
- R9: A write to one configuration word leaves the fields of the other words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word address (1..3 valid) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| evt_i | input | 128 | Event vector; bits 0..3 are combined events |
| ack_i | input | 12 | Per-output pending acknowledge; bit k is output k+4 |
| irq_o | output | 12 | Registered interrupt requests; bit k is output k+4 |
| top_valid_o | output | 1 | Some output is pending |
| top_num_o | output | 4 | Number (4..15) of the highest-priority pending output |

## Verification
The bench builds the block with its default parameters: 128 events, twelve outputs and four 7-bit fields per 32-bit word. These values make it possible to select both ends of the event range (combined event 0 and raw event 127). They also allow fields at every byte lane of every word, and all three words, so the priority resolver sees its full output range. A table walk reprograms single fields and fires single events, including events that several outputs share. Directed cases then cover a simultaneous acknowledge and event, a partial acknowledge, priority hand-over, and ignored writes to address 0.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    localparam int EVT_COUNT      = 128;
    localparam int OUT_COUNT      = 12;
    localparam int OUT_BASE       = 4;
    localparam int FIELDS_PER_REG = 4;
    localparam int FIELD_STRIDE   = 8;
    localparam int CFG_DATA_W     = 32;

    // Reset source for output slot k: event number equal to the output number.
    function automatic int default_src(int k);
        return k + OUT_BASE;
    endfunction

    // Lowest bit position of the field for slot k inside its word.
    function automatic int field_lsb(int k);
        return (k % FIELDS_PER_REG) * FIELD_STRIDE;
    endfunction

    // Word address (1-based) that holds the field for slot k.
    function automatic int word_of(int k);
        return k / FIELDS_PER_REG + 1;
    endfunction
endpackage

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
    import irq_sel_pkg::*;
#(
    parameter int NUM_OUT = OUT_COUNT,
    parameter int SEL_W   = 7,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = CFG_DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic [DATA_W-1:0]        cfg_rdata,
    output logic [NUM_OUT*SEL_W-1:0] sel_o
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_field
        localparam int LSB  = field_lsb(k);
        localparam int WORD = word_of(k);
        logic [SEL_W-1:0] src_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q <= SEL_W'(default_src(k));
            end else if (cfg_we && cfg_addr == ADDR_W'(WORD)) begin
                src_q <= cfg_wdata[LSB +: SEL_W];
            end
        end

        assign sel_o[k*SEL_W +: SEL_W] = src_q;
    end

    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NUM_OUT; k++) begin
            if (cfg_addr == ADDR_W'(word_of(k))) begin
                cfg_rdata[field_lsb(k) +: SEL_W] = sel_o[k*SEL_W +: SEL_W];
            end
        end
    end
endmodule

// File: rtl/irq_sel_mux.sv
module irq_sel_mux #(
    parameter int NUM_EVT = 128,
    parameter int NUM_OUT = 12,
    parameter int SEL_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_EVT-1:0]       evt_i,
    input  logic [NUM_OUT*SEL_W-1:0] sel_i,
    output logic [NUM_OUT-1:0]       hit_o,
    output logic [NUM_OUT-1:0]       irq_o
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_route
        logic [SEL_W-1:0] src;
        logic             req_q;

        assign src      = sel_i[k*SEL_W +: SEL_W];
        assign hit_o[k] = evt_i[src];

        always_ff @(posedge clk) begin
            if (rst) req_q <= 1'b0;
            else     req_q <= hit_o[k];
        end

        assign irq_o[k] = req_q;
    end
endmodule

// File: rtl/irq_pend_prio.sv
module irq_pend_prio
    import irq_sel_pkg::*;
#(
    parameter int NUM_OUT = OUT_COUNT,
    parameter int NUM_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OUT-1:0] hit_i,
    input  logic [NUM_OUT-1:0] ack_i,
    output logic [NUM_OUT-1:0] pend_o,
    output logic               top_valid_o,
    output logic [NUM_W-1:0]   top_num_o
);
    logic [NUM_OUT-1:0] pend_q;

    // A new event in the acknowledge cycle wins, so it is never lost.
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~ack_i) | hit_i;
    end

    always_comb begin
        top_valid_o = |pend_q;
        top_num_o   = '0;
        for (int i = NUM_OUT - 1; i >= 0; i--) begin
            if (pend_q[i]) top_num_o = NUM_W'(i + OUT_BASE);
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
    import irq_sel_pkg::*;
#(
    parameter int NUM_EVT = EVT_COUNT,
    parameter int NUM_OUT = OUT_COUNT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_addr,
    input  logic [CFG_DATA_W-1:0]    cfg_wdata,
    output logic [CFG_DATA_W-1:0]    cfg_rdata,
    input  logic [NUM_EVT-1:0]       evt_i,
    input  logic [NUM_OUT-1:0]       ack_i,
    output logic [NUM_OUT-1:0]       irq_o,
    output logic                     top_valid_o,
    output logic [3:0]               top_num_o
);
    localparam int SEL_W = $clog2(NUM_EVT);
    localparam int NUM_W = $clog2(OUT_BASE + NUM_OUT);

    logic [NUM_OUT*SEL_W-1:0] sel_flat;
    logic [NUM_OUT-1:0]       hit;
    logic [NUM_OUT-1:0]       pend_q;

    irq_sel_regs #(
        .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .ADDR_W(2), .DATA_W(CFG_DATA_W)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_o(sel_flat)
    );

    irq_sel_mux #(
        .NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)
    ) u_mux (
        .clk(clk), .rst(rst), .evt_i(evt_i), .sel_i(sel_flat),
        .hit_o(hit), .irq_o(irq_o)
    );

    irq_pend_prio #(
        .NUM_OUT(NUM_OUT), .NUM_W(NUM_W)
    ) u_prio (
        .clk(clk), .rst(rst), .hit_i(hit), .ack_i(ack_i), .pend_o(pend_q),
        .top_valid_o(top_valid_o), .top_num_o(top_num_o)
    );
endmodule

// File: rtl/irq_src_router_chk.sv
module irq_src_router_chk #(
    parameter int NUM_OUT = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_OUT-1:0] ack_i,
    input logic [NUM_OUT-1:0] irq_o,
    input logic [NUM_OUT-1:0] pend_q,
    input logic               top_valid_o,
    input logic [3:0]         top_num_o
);
    logic [NUM_OUT-1:0] below_mask;
    logic [NUM_OUT-1:0] top_bit;

    always_comb begin
        below_mask = '0;
        top_bit    = '0;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (32'(top_num_o) > 32'(i + 4)) below_mask[i] = 1'b1;
            if (32'(top_num_o) == 32'(i + 4)) top_bit[i] = 1'b1;
        end
    end

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_o == '0 && pend_q == '0 && !top_valid_o));

    // R5: an unacknowledged pending bit persists
    a_r5_pend_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(pend_q & ~ack_i)) == $past(pend_q & ~ack_i)));

    // R6: a request on an output is always reflected as pending
    a_r6_irq_implies_pend: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~pend_q) == '0);

    // R6: after an acknowledge the bit is clear unless a new request arrived
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_i != '0) |=> (($past(ack_i) & pend_q & ~irq_o) == '0));

    // R7: valid flag tracks any pending bit
    a_r7_valid_any: assert property (@(posedge clk) disable iff (rst)
        top_valid_o == (pend_q != '0));

    // R7: reported number is pending and nothing of higher priority is
    a_r7_top_lowest: assert property (@(posedge clk) disable iff (rst)
        top_valid_o |-> ($onehot0(top_bit) && (pend_q & top_bit) != '0
                         && (pend_q & below_mask) == '0));
endmodule

bind irq_src_router irq_src_router_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk(clk), .rst(rst), .ack_i(ack_i), .irq_o(irq_o), .pend_q(pend_q),
    .top_valid_o(top_valid_o), .top_num_o(top_num_o)
);

// File: tb/test_irq_src_router.sv
module test_irq_src_router;
    localparam int NE = 128;
    localparam int NO = 12;

    typedef struct packed {
        logic [3:0] slot;
        logic [6:0] evt;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  7'd0},   '{4'd1,  7'd3},   '{4'd11, 7'd127}, '{4'd5, 7'd64},
        '{4'd6,  7'd64},  '{4'd2,  7'd31},  '{4'd3,  7'd32},  '{4'd8, 7'd96},
        '{4'd10, 7'd4},   '{4'd7,  7'd100}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NE-1:0] evt_i = '0;
    logic [NO-1:0] ack_i = '0;
    logic [NO-1:0] irq_o;
    logic          top_valid_o;
    logic [3:0]    top_num_o;

    int checks = 0;
    int errors = 0;
    logic [6:0] sel_m [NO];

    always #5 clk = ~clk;

    irq_src_router i_irq_src_router (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_i(evt_i),
        .ack_i(ack_i), .irq_o(irq_o), .top_valid_o(top_valid_o),
        .top_num_o(top_num_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    function automatic logic [31:0] pack(input int w);
        logic [31:0] p = '0;
        for (int f = 0; f < 4; f++) p[f*8 +: 7] = sel_m[w*4 + f];
        return p;
    endfunction

    function automatic logic [4:0] top_of(input logic [NO-1:0] m);
        logic [4:0] r = '0;
        for (int j = NO - 1; j >= 0; j--) if (m[j]) r = {1'b1, 4'(j + 4)};
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NO; k++) sel_m[k] = 7'(k + 4);
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;

        // R1: reset state
        rd_chk("R1 word1 default", 2'd1, pack(0));
        rd_chk("R1 word2 default", 2'd2, pack(1));
        rd_chk("R1 word3 default", 2'd3, pack(2));
        chk("R1 irq idle", 32'(irq_o), 32'h0);
        chk("R1 no pending", {31'h0, top_valid_o}, 32'h0);

        // Table walk: R2 layout, R3 latency, R4 any source / shared source
        for (int v = 0; v < NVEC; v++) begin
            logic [NO-1:0] exp_irq;
            int w;
            sel_m[VECS[v].slot] = VECS[v].evt;
            w = int'(VECS[v].slot) / 4;
            wr(2'(w + 1), pack(w));
            rd_chk("R2 readback", 2'(w + 1), pack(w));
            exp_irq = '0;
            for (int j = 0; j < NO; j++) if (sel_m[j] == VECS[v].evt) exp_irq[j] = 1'b1;
            evt_i = '0;
            evt_i[VECS[v].evt] = 1'b1;
            tick();
            evt_i = '0;
            chk("R3 R4 irq routed", 32'(irq_o), 32'(exp_irq));
            chk("R7 top after event", 32'({top_valid_o, top_num_o}), 32'(top_of(exp_irq)));
            ack_i = '1;
            tick();
            ack_i = '0;
            chk("R6 ack all clears", {31'h0, top_valid_o}, 32'h0);
        end

        // R2: address 0 write ignored, reads zero; R9 other words intact
        wr(2'd1, 32'h0D0C0B0A);
        wr(2'd2, 32'h11100F0E);
        wr(2'd3, 32'h15141312);
        wr(2'd0, 32'hFFFFFFFF);
        rd_chk("R2 addr0 reads zero", 2'd0, 32'h0);
        rd_chk("R2 addr0 write ignored", 2'd1, 32'h0D0C0B0A);
        wr(2'd2, 32'hFFFFFFFF);
        rd_chk("R2 unused bits zero", 2'd2, 32'h7F7F7F7F);
        rd_chk("R9 word1 untouched", 2'd1, 32'h0D0C0B0A);
        rd_chk("R9 word3 untouched", 2'd3, 32'h15141312);
        wr(2'd2, 32'h11100F0E);

        // R5: pending outlives a one-cycle event on output 4
        evt_i[10] = 1'b1;
        tick();
        evt_i = '0;
        tick();
        chk("R5 irq dropped", 32'(irq_o), 32'h0);
        chk("R5 pending held", 32'({top_valid_o, top_num_o}), 32'h14);

        // R7 R8: outputs 4 and 6 pending; ack 6 only, then 4
        evt_i[12] = 1'b1;
        tick();
        evt_i = '0;
        ack_i = 12'h004;
        tick();
        ack_i = '0;
        chk("R8 ack low leaves high", 32'({top_valid_o, top_num_o}), 32'h14);
        evt_i[12] = 1'b1;
        tick();
        evt_i = '0;
        ack_i = 12'h001;
        tick();
        ack_i = '0;
        chk("R7 priority hands over", 32'({top_valid_o, top_num_o}), 32'h16);
        ack_i = 12'h004;
        tick();
        ack_i = '0;
        chk("R7 none pending", {31'h0, top_valid_o}, 32'h0);

        // R6: acknowledge in the same cycle as a new event keeps output 7 pending
        evt_i[13] = 1'b1;
        tick();
        ack_i = 12'h008;
        tick();
        evt_i = '0;
        ack_i = '0;
        chk("R6 set wins over ack", 32'({top_valid_o, top_num_o}), 32'h17);
        ack_i = 12'h008;
        tick();
        ack_i = '0;
        chk("R6 ack clears", {31'h0, top_valid_o}, 32'h0);

        // R4: combined event 0 shared by outputs 12..15
        wr(2'd3, 32'h00000000);
        evt_i[0] = 1'b1;
        tick();
        evt_i = '0;
        chk("R4 shared combined event", 32'(irq_o), 32'hF00);
        chk("R7 top of shared", 32'({top_valid_o, top_num_o}), 32'h1C);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule